// File: doc/BRIEF.md
# UART Host Bus Interface and Register Decoder

This block sits between a processor bus and the rest of a UART. It decides whether the UART is addressed and which of eight register addresses an access targets. It accepts read and write commands on either an active-high or an active-low strobe. It stores the configuration registers that belong on the bus side: line control, interrupt enable, scratch, and the two bytes of the baud divisor. Reads of status and receive data are passed through from inputs that other parts of the UART drive.

An address strobe lets the bus present the select and address lines briefly. While the strobe is low, those lines flow straight through and are used as they stand. While the strobe is high, the values that were present at the last clock with the strobe low are held.

The top bit of the line control register chooses the bank for addresses 0 and 1. With the bit set, those addresses reach the divisor bytes. With it clear, they reach the data path and the interrupt enable register. Writes to the transmit holding address and reads of the receive buffer address each produce a one-cycle pulse for the data path. That data path is outside this block.

Top module: `uart_host_front`

## Requirements
- R1: The block is addressed only when `sel_a`=1, `sel_b`=1 and `sel_c_n`=0. In any other combination, writes change no register, `rd_active` stays 0 and `rdata` reads 0.
- R2: While `addr_strobe` is 0, `reg_sel` and the three select lines act on reads at once, within the same cycle and with no clock edge in between.
- R3: While `addr_strobe` is 1, the block uses the select and address values from the last clock edge at which the strobe was 0. Changes on those lines are ignored for both reads and writes.
- R4: A read is active (`rd_active`=1) when the block is addressed and either `rd_hi`=1 or `rd_lo_n`=0.
- R5: A write is active when the block is addressed and either `wr_hi`=1 or `wr_lo_n`=0. The target register takes `wdata` at the first clock at which the write is active. If the write is held active, later changes of `wdata` have no effect.
- R6: `line_ctrl` bit 7 is the divisor-access bit. While it is 1, address 0 reads and writes the divisor low byte (`divisor[7:0]`) and address 1 the high byte (`divisor[15:8]`). Address 3 is the line control register.
- R7: While the divisor-access bit is 0, a read of address 0 returns `rx_data_in`, and address 1 reads and writes the interrupt enable register (`int_enable`).
- R8: Reads of addresses 2, 5 and 6 return `iid_in`, `lsr_in` and `msr_in` respectively. Writes to those addresses change no register.
- R9: Address 7 is a scratch register that reads back what was last written. Address 4 always reads 0 and ignores writes.
- R10: A write to address 0 with the divisor-access bit 0 loads `tx_data` and sets `tx_load` for exactly one cycle, in the cycle after the write begins. A divisor write gives no `tx_load`.
- R11: The start of a read of address 0 with the divisor-access bit 0 sets `rx_take` for exactly one cycle. A held read gives only one pulse, and divisor reads give none.
- R12: Synchronous reset clears `line_ctrl`, `int_enable`, the scratch register, `divisor`, `tx_load` and `rx_take`. `rdata` is 0 whenever no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | Select line, active high |
| sel_b | input | 1 | Select line, active high |
| sel_c_n | input | 1 | Select line, active low |
| addr_strobe | input | 1 | Holds select/address while high, transparent while low |
| reg_sel | input | 3 | Register address |
| rd_hi | input | 1 | Read command, active high |
| rd_lo_n | input | 1 | Read command, active low |
| wr_hi | input | 1 | Write command, active high |
| wr_lo_n | input | 1 | Write command, active low |
| wdata | input | 8 | Write data |
| rx_data_in | input | 8 | Receive buffer byte from data path |
| iid_in | input | 8 | Interrupt identification byte |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| rdata | output | 8 | Read data, 0 when no read is active |
| rd_active | output | 1 | Qualified read in progress |
| line_ctrl | output | 8 | Line control register |
| int_enable | output | 8 | Interrupt enable register |
| divisor | output | 16 | Baud divisor {high, low} |
| tx_data | output | 8 | Last byte written to transmit holding address |
| tx_load | output | 1 | One-cycle pulse on transmit holding write |
| rx_take | output | 1 | One-cycle pulse on receive buffer read |

## Verification
The bench flips the divisor-access bit and revisits addresses 0 and 1. A wrong bank decode would overwrite the interrupt enable register, or it would raise `tx_load` on a divisor write. The bench holds a write active while the data changes. A level-triggered write would keep the last byte instead of the first. With the strobe high, the bench changes the address and drops a select line. A design that did not freeze those lines would touch the wrong register or refuse the access. The bench also tries every bad select combination and both strobe polarities, and it writes to the read-only and reserved addresses. A decode error there shows up as a changed register or nonzero read data.

// File: rtl/uhf_pkg.sv
package uhf_pkg;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;

    // register address map (addresses 0 and 1 banked by the divisor-access bit)
    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_IID  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LCR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RSV  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LST  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MST  = 3'd6;
    localparam logic [ADDR_W-1:0] A_SCR  = 3'd7;

    // select line pattern that addresses the block: {sel_a, sel_b, sel_c_n}
    localparam logic [SEL_W-1:0] SEL_MATCH = 3'b110;
endpackage

// File: rtl/uhf_addr_hold.sv
module uhf_addr_hold
    import uhf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [AW-1:0] addr_in,
    input  logic [SW-1:0] sel_in,
    output logic [AW-1:0] addr_out,
    output logic [SW-1:0] sel_out
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [SW-1:0] sel;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!strobe) begin
            h_d.addr = addr_in;
            h_d.sel  = sel_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    // transparent while strobe low, frozen copy while high
    assign addr_out = strobe ? h_q.addr : addr_in;
    assign sel_out  = strobe ? h_q.sel  : sel_in;
endmodule

// File: rtl/uhf_access_ctl.sv
module uhf_access_ctl
    import uhf_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel,
    input  logic          rd_hi,
    input  logic          rd_lo_n,
    input  logic          wr_hi,
    input  logic          wr_lo_n,
    output logic          rd_act,
    output logic          wr_act,
    output logic          rd_rise,
    output logic          wr_rise
);
    typedef struct packed {
        logic rd_prev;
        logic wr_prev;
    } edge_t;

    edge_t e_d, e_q;
    logic  addressed;

    always_comb begin
        addressed = (sel == SEL_MATCH);
        rd_act    = addressed && (rd_hi || !rd_lo_n);
        wr_act    = addressed && (wr_hi || !wr_lo_n);
        rd_rise   = rd_act && !e_q.rd_prev;
        wr_rise   = wr_act && !e_q.wr_prev;
        e_d.rd_prev = rd_act;
        e_d.wr_prev = wr_act;
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end
endmodule

// File: rtl/uhf_reg_file.sv
module uhf_reg_file
    import uhf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_rise,
    input  logic          rd_rise,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lcr,
    output logic [DW-1:0] ien,
    output logic [DW-1:0] scr,
    output logic [DW-1:0] div_lo,
    output logic [DW-1:0] div_hi,
    output logic [DW-1:0] tx_byte,
    output logic          tx_pulse,
    output logic          rx_pulse
);
    localparam int DLAB_BIT = DW - 1;

    typedef struct packed {
        logic [DW-1:0] lcr;
        logic [DW-1:0] ien;
        logic [DW-1:0] scr;
        logic [DW-1:0] dlo;
        logic [DW-1:0] dhi;
        logic [DW-1:0] txb;
        logic          txp;
        logic          rxp;
    } regs_t;

    regs_t r_d, r_q;
    logic  dlab;

    always_comb begin
        r_d     = r_q;
        r_d.txp = 1'b0;
        r_d.rxp = 1'b0;
        dlab    = r_q.lcr[DLAB_BIT];
        if (wr_rise) begin
            case (addr)
                A_DATA: begin
                    if (dlab) r_d.dlo = wdata;
                    else begin
                        r_d.txb = wdata;
                        r_d.txp = 1'b1;
                    end
                end
                A_IEN: begin
                    if (dlab) r_d.dhi = wdata;
                    else      r_d.ien = wdata;
                end
                A_LCR:   r_d.lcr = wdata;
                A_SCR:   r_d.scr = wdata;
                default: ;
            endcase
        end
        if (rd_rise && (addr == A_DATA) && !dlab) r_d.rxp = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign lcr      = r_q.lcr;
    assign ien      = r_q.ien;
    assign scr      = r_q.scr;
    assign div_lo   = r_q.dlo;
    assign div_hi   = r_q.dhi;
    assign tx_byte  = r_q.txb;
    assign tx_pulse = r_q.txp;
    assign rx_pulse = r_q.rxp;
endmodule

// File: rtl/uart_host_front.sv
module uart_host_front
    import uhf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_a,
    input  logic            sel_b,
    input  logic            sel_c_n,
    input  logic            addr_strobe,
    input  logic [2:0]      reg_sel,
    input  logic            rd_hi,
    input  logic            rd_lo_n,
    input  logic            wr_hi,
    input  logic            wr_lo_n,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   rx_data_in,
    input  logic [DW-1:0]   iid_in,
    input  logic [DW-1:0]   lsr_in,
    input  logic [DW-1:0]   msr_in,
    output logic [DW-1:0]   rdata,
    output logic            rd_active,
    output logic [DW-1:0]   line_ctrl,
    output logic [DW-1:0]   int_enable,
    output logic [2*DW-1:0] divisor,
    output logic [DW-1:0]   tx_data,
    output logic            tx_load,
    output logic            rx_take
);
    localparam int DLAB_BIT = DW - 1;

    logic [ADDR_W-1:0] addr_eff;
    logic [SEL_W-1:0]  sel_eff;
    logic              rd_act, wr_act, rd_rise, wr_rise;
    logic [DW-1:0]     scr, div_lo, div_hi;

    uhf_addr_hold #(.AW(ADDR_W), .SW(SEL_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .strobe   (addr_strobe),
        .addr_in  (reg_sel),
        .sel_in   ({sel_a, sel_b, sel_c_n}),
        .addr_out (addr_eff),
        .sel_out  (sel_eff)
    );

    uhf_access_ctl #(.SW(SEL_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_eff),
        .rd_hi   (rd_hi),
        .rd_lo_n (rd_lo_n),
        .wr_hi   (wr_hi),
        .wr_lo_n (wr_lo_n),
        .rd_act  (rd_act),
        .wr_act  (wr_act),
        .rd_rise (rd_rise),
        .wr_rise (wr_rise)
    );

    uhf_reg_file #(.AW(ADDR_W), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_rise  (wr_rise),
        .rd_rise  (rd_rise),
        .addr     (addr_eff),
        .wdata    (wdata),
        .lcr      (line_ctrl),
        .ien      (int_enable),
        .scr      (scr),
        .div_lo   (div_lo),
        .div_hi   (div_hi),
        .tx_byte  (tx_data),
        .tx_pulse (tx_load),
        .rx_pulse (rx_take)
    );

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            case (addr_eff)
                A_DATA:  rdata = line_ctrl[DLAB_BIT] ? div_lo : rx_data_in;
                A_IEN:   rdata = line_ctrl[DLAB_BIT] ? div_hi : int_enable;
                A_IID:   rdata = iid_in;
                A_LCR:   rdata = line_ctrl;
                A_LST:   rdata = lsr_in;
                A_MST:   rdata = msr_in;
                A_SCR:   rdata = scr;
                default: rdata = '0;
            endcase
        end
    end

    assign rd_active = rd_act;
    assign divisor   = {div_hi, div_lo};
endmodule

// File: rtl/uhf_checker.sv
module uhf_checker #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_act,
    input logic            rd_act,
    input logic            rd_active,
    input logic [DW-1:0]   rdata,
    input logic [DW-1:0]   line_ctrl,
    input logic [2*DW-1:0] divisor,
    input logic            tx_load,
    input logic            rx_take
);
    // R10
    tx_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    // R11
    rx_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_take |=> !rx_take);

    // R10
    tx_bank_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> !line_ctrl[DW-1]);

    // R12
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_active |-> (rdata == '0));

    // R5
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_act) |-> $stable(divisor));

    // R11
    rx_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rx_take |-> $past(rd_act));
endmodule

bind uart_host_front uhf_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_act    (wr_act),
    .rd_act    (rd_act),
    .rd_active (rd_active),
    .rdata     (rdata),
    .line_ctrl (line_ctrl),
    .divisor   (divisor),
    .tx_load   (tx_load),
    .rx_take   (rx_take)
);

// File: tb/sim_uart_host_front.sv
module sim_uart_host_front;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_a = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
    logic       addr_strobe = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       rd_hi = 1'b0, rd_lo_n = 1'b1, wr_hi = 1'b0, wr_lo_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rx_data_in = 8'hA5, iid_in = 8'hC1, lsr_in = 8'h60, msr_in = 8'hB0;
    logic [7:0] rdata, line_ctrl, int_enable, tx_data;
    logic       rd_active, tx_load, rx_take;
    logic [15:0] divisor;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_host_front u0 (
        .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .addr_strobe(addr_strobe), .reg_sel(reg_sel), .rd_hi(rd_hi), .rd_lo_n(rd_lo_n),
        .wr_hi(wr_hi), .wr_lo_n(wr_lo_n), .wdata(wdata), .rx_data_in(rx_data_in),
        .iid_in(iid_in), .lsr_in(lsr_in), .msr_in(msr_in), .rdata(rdata),
        .rd_active(rd_active), .line_ctrl(line_ctrl), .int_enable(int_enable),
        .divisor(divisor), .tx_data(tx_data), .tx_load(tx_load), .rx_take(rx_take)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one write; uses current select and strobe levels
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input bit lowpol);
        @(negedge clk);
        reg_sel = a; wdata = d;
        if (lowpol) wr_lo_n = 1'b0; else wr_hi = 1'b1;
        @(negedge clk);
        wr_lo_n = 1'b1; wr_hi = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input bit lowpol,
                            output logic [7:0] v, output logic act, output logic pulse);
        @(negedge clk);
        reg_sel = a;
        if (lowpol) rd_lo_n = 1'b0; else rd_hi = 1'b1;
        #1;
        v = rdata; act = rd_active;
        @(negedge clk);
        pulse = rx_take;
        rd_lo_n = 1'b1; rd_hi = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 line_ctrl", {8'h0, line_ctrl}, 16'h0);
        chk("R12 int_enable", {8'h0, int_enable}, 16'h0);
        chk("R12 divisor", divisor, 16'h0);
        chk("R12 pulses", {14'h0, tx_load, rx_take}, 16'h0);
        chk("R12 idle rdata", {8'h0, rdata}, 16'h0);
    endtask

    task automatic t_scratch_reserved();
        logic [7:0] v; logic a, p;
        bus_write(3'd7, 8'h3C, 1'b0);
        bus_read(3'd7, 1'b0, v, a, p);
        chk("R9 scratch readback", {8'h0, v}, 16'h003C);
        bus_write(3'd4, 8'hFF, 1'b0);
        bus_read(3'd4, 1'b0, v, a, p);
        chk("R9 reserved reads zero", {8'h0, v}, 16'h0);
    endtask

    task automatic t_rx_read();
        logic [7:0] v; logic a, p;
        bus_read(3'd0, 1'b0, v, a, p);
        chk("R7 rx data", {8'h0, v}, 16'h00A5);
        chk("R11 rx_take pulse", {15'h0, p}, 16'h1);
        @(negedge clk);
        chk("R11 rx_take one cycle", {15'h0, rx_take}, 16'h0);
        // held read: one pulse only
        @(negedge clk); reg_sel = 3'd0; rd_hi = 1'b1;
        @(negedge clk); chk("R11 held read first", {15'h0, rx_take}, 16'h1);
        @(negedge clk); chk("R11 held read no repeat", {15'h0, rx_take}, 16'h0);
        rd_hi = 1'b0;
    endtask

    task automatic t_polarity();
        logic [7:0] v; logic a, p;
        bus_read(3'd7, 1'b1, v, a, p);
        chk("R4 low-polarity read", {8'h0, v}, 16'h003C);
        chk("R4 rd_active", {15'h0, a}, 16'h1);
        bus_write(3'd1, 8'h0F, 1'b1);
        chk("R5 low-polarity write", {8'h0, int_enable}, 16'h000F);
        bus_read(3'd1, 1'b0, v, a, p);
        chk("R7 ien read", {8'h0, v}, 16'h000F);
    endtask

    task automatic t_tx();
        bus_write(3'd0, 8'h5A, 1'b0);
        chk("R10 tx_load", {15'h0, tx_load}, 16'h1);
        chk("R10 tx_data", {8'h0, tx_data}, 16'h005A);
        @(negedge clk);
        chk("R10 tx_load one cycle", {15'h0, tx_load}, 16'h0);
    endtask

    task automatic t_divisor();
        logic [7:0] v; logic a, p;
        bus_write(3'd3, 8'h83, 1'b0);
        chk("R6 line_ctrl", {8'h0, line_ctrl}, 16'h0083);
        bus_write(3'd0, 8'h34, 1'b0);
        chk("R10 no tx_load on divisor", {15'h0, tx_load}, 16'h0);
        bus_write(3'd1, 8'h12, 1'b0);
        chk("R6 divisor", divisor, 16'h1234);
        chk("R6 ien untouched", {8'h0, int_enable}, 16'h000F);
        bus_read(3'd0, 1'b0, v, a, p);
        chk("R6 read div low", {8'h0, v}, 16'h0034);
        chk("R11 no rx_take on divisor", {15'h0, p}, 16'h0);
        bus_read(3'd1, 1'b0, v, a, p);
        chk("R6 read div high", {8'h0, v}, 16'h0012);
        bus_write(3'd3, 8'h03, 1'b0);
        bus_read(3'd1, 1'b0, v, a, p);
        chk("R7 bank back to ien", {8'h0, v}, 16'h000F);
        bus_read(3'd3, 1'b0, v, a, p);
        chk("R6 lcr read", {8'h0, v}, 16'h0003);
    endtask

    task automatic t_status();
        logic [7:0] v; logic a, p;
        bus_read(3'd2, 1'b0, v, a, p); chk("R8 iid", {8'h0, v}, 16'h00C1);
        bus_read(3'd5, 1'b0, v, a, p); chk("R8 lsr", {8'h0, v}, 16'h0060);
        bus_read(3'd6, 1'b0, v, a, p); chk("R8 msr", {8'h0, v}, 16'h00B0);
        bus_write(3'd5, 8'h00, 1'b0);
        bus_write(3'd2, 8'h00, 1'b0);
        bus_write(3'd6, 8'h00, 1'b0);
        chk("R8 writes ignored lcr", {8'h0, line_ctrl}, 16'h0003);
        chk("R8 writes ignored ien", {8'h0, int_enable}, 16'h000F);
        bus_read(3'd7, 1'b0, v, a, p); chk("R8 writes ignored scr", {8'h0, v}, 16'h003C);
    endtask

    task automatic t_select();
        logic [7:0] v; logic a, p;
        for (int k = 0; k < 8; k++) begin
            if (k == 3'b110) continue;
            {sel_a, sel_b, sel_c_n} = 3'(k);
            bus_write(3'd7, 8'h99, 1'b0);
            bus_read(3'd7, 1'b0, v, a, p);
            chk("R1 deselected rdata", {8'h0, v}, 16'h0);
            chk("R1 deselected rd_active", {15'h0, a}, 16'h0);
        end
        {sel_a, sel_b, sel_c_n} = 3'b110;
        bus_read(3'd7, 1'b0, v, a, p);
        chk("R1 scratch kept", {8'h0, v}, 16'h003C);
    endtask

    task automatic t_transparent();
        @(negedge clk);
        reg_sel = 3'd3; rd_hi = 1'b1; #1;
        chk("R2 pass-through lcr", {8'h0, rdata}, 16'h0003);
        reg_sel = 3'd7; #1;
        chk("R2 pass-through scr", {8'h0, rdata}, 16'h003C);
        rd_hi = 1'b0;
    endtask

    task automatic t_freeze();
        logic [7:0] v; logic a, p;
        @(negedge clk); reg_sel = 3'd7; addr_strobe = 1'b0;
        @(negedge clk); addr_strobe = 1'b1; reg_sel = 3'd3; sel_a = 1'b0;
        bus_read(3'd3, 1'b0, v, a, p);
        chk("R3 frozen read", {8'h0, v}, 16'h003C);
        bus_write(3'd3, 8'h77, 1'b0);
        chk("R3 lcr untouched", {8'h0, line_ctrl}, 16'h0003);
        @(negedge clk); addr_strobe = 1'b0; sel_a = 1'b1;
        bus_read(3'd7, 1'b0, v, a, p);
        chk("R3 frozen write target", {8'h0, v}, 16'h0077);
    endtask

    task automatic t_held_write();
        logic [7:0] v; logic a, p;
        @(negedge clk); reg_sel = 3'd7; wdata = 8'h11; wr_hi = 1'b1;
        @(negedge clk); wdata = 8'h22;
        @(negedge clk); wr_hi = 1'b0;
        bus_read(3'd7, 1'b0, v, a, p);
        chk("R5 held write first byte", {8'h0, v}, 16'h0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_scratch_reserved();
        t_rx_read();
        t_polarity();
        t_tx();
        t_divisor();
        t_status();
        t_select();
        t_transparent();
        t_freeze();
        t_held_write();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end
endmodule